// File: doc/BRIEF.md
# Serial Port Interrupt Register Bank

This block holds the interrupt state of a serial port. Event lines from the receiver, the transmitter and the FIFO logic each latch a sticky status bit. A mask chooses which latched bits may raise the single interrupt line. Software reaches the block through a 32-bit register window with an 8-bit byte address.

The mask cannot be written directly. It changes only through two alias registers: one sets mask bits where a one is written, and the other clears them. Both aliases read back as zero. Latched status bits are cleared by writing a one to their position. A separate channel view reports the live FIFO conditions whatever the mask holds.

Event bit positions are shared by the mask, the status and the alias registers: 0 RX trigger, 1 RX empty, 2 RX full, 3 TX empty, 4 TX full, 5 overrun, 6 framing error, 7 parity error, 8 RX timeout. Positions 9 to 12 are storage-only.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset the mask (0x10) and the status (0x14) both read 0 and `irq_o` is low.
- R2: A write to 0x08 sets every mask bit where the data has a one and leaves the others as they were. The mask then reads back at 0x10.
- R3: A write to 0x0C clears every mask bit where the data has a one and leaves the others as they were.
- R4: Reads at 0x08 and 0x0C return 0. A write to 0x10 leaves the mask unchanged.
- R5: A 0-to-1 transition on `evt_i[k]` sets status bit k at the clock edge where it is first seen high. A line held high does not set the bit again after it is cleared.
- R6: Writing data to 0x14 clears every status bit where the data has a one. Bits where the data has a zero are kept.
- R7: When an event rises on a bit in the same cycle that a status write clears that bit, the bit ends up set.
- R8: `irq_o` is the registered OR of (status AND mask). It changes one clock after the status or mask changes, and a masked status bit never raises it.
- R9: Reading 0x2C returns `live_i[0]` at bit 0, `live_i[1]` at bit 1, `live_i[2]` at bit 3 and `live_i[3]` at bit 4, with all other bits 0. This read does not depend on the mask.
- R10: Only bits 12:0 of the mask and the status exist. Write data above bit 12 is ignored, those bits read 0, and status bits 9 to 12 are never set.
- R11: Any other address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_i | input | 9 | Event lines, one per status bit 0 to 8 |
| live_i | input | 4 | Live conditions: RX trigger, RX empty, TX empty, TX full |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that an access lasts exactly one cycle, and that the address and data do not change during the clock edge that takes the write. The bench meets this by changing every input only on the falling edge. The assertions also assume the event lines are level signals sampled once per clock: a pulse shorter than a clock may be lost. The bench holds each event for at least one full cycle and lowers it again before it expects a new edge. The bench creates the same-cycle race between a status clear and an event rise on purpose, both in directed steps and in the randomized phase.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   localparam int unsigned REG_W = 32;

   localparam logic [7:0] OFS_SETM = 8'h08;
   localparam logic [7:0] OFS_CLRM = 8'h0C;
   localparam logic [7:0] OFS_MASK = 8'h10;
   localparam logic [7:0] OFS_STAT = 8'h14;
   localparam logic [7:0] OFS_CHAN = 8'h2C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SETM,
      SEL_CLRM,
      SEL_MASK,
      SEL_STAT,
      SEL_CHAN
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [7:0] a);
      reg_sel_e s;
      case (a)
         OFS_SETM: s = SEL_SETM;
         OFS_CLRM: s = SEL_CLRM;
         OFS_MASK: s = SEL_MASK;
         OFS_STAT: s = SEL_STAT;
         OFS_CHAN: s = SEL_CHAN;
         default:  s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/uirq_edge.sv
module uirq_edge #(
   parameter int unsigned N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);

   generate
      if (N < 1) begin : g_bad_n
         $error("uirq_edge: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] prev_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[i] <= 1'b0;
         else        prev_q[i] <= lvl_i[i];
      end
      assign rise_o[i] = lvl_i[i] & ~prev_q[i];

      // R5: a held line yields one rise only
      a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[i] |=> !rise_o[i]);
   end

endmodule

// File: rtl/uirq_mask.sv
module uirq_mask #(
   parameter int unsigned W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_o
);

   generate
      if (W < 1 || W > 32) begin : g_bad_w
         $error("uirq_mask: W out of range");
      end
   endgenerate

   logic [W-1:0] mask_q;
   logic [W-1:0] mask_d;

   always_comb begin
      mask_d = mask_q;
      if (set_we) mask_d = mask_d | wdata;
      if (clr_we) mask_d = mask_d & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   assign mask_o = mask_q;

   a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> ((mask_q & $past(wdata)) == $past(wdata)));

   a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((mask_q & $past(wdata)) == '0));

   a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(mask_q));

endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
   parameter int unsigned W = 13,
   parameter int unsigned N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rise_i,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] stat_o
);

   generate
      if (N > W) begin : g_bad_n
         $error("uirq_status: more events than status bits");
      end
   endgenerate

   logic [W-1:0] rise_w;
   logic [W-1:0] stat_q;
   logic [W-1:0] clr_v;

   generate
      if (W > N) begin : g_pad
         assign rise_w = {{(W-N){1'b0}}, rise_i};
      end else begin : g_flat
         assign rise_w = rise_i;
      end
   endgenerate

   assign clr_v = clr_we ? wdata : '0;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < N) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         stat_q[i] <= 1'b0;
            else if (rise_w[i]) stat_q[i] <= 1'b1;
            else if (clr_v[i])  stat_q[i] <= 1'b0;
         end
      end else begin : g_nosrc
         assign stat_q[i] = 1'b0;
      end
   end

   assign stat_o = stat_q;

   // R5 and R7: a rise always lands, even against a clear
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_w != '0) |=> ((stat_q & $past(rise_w)) == $past(rise_w)));

   a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((stat_q & $past(wdata & ~rise_w)) == '0));

   a_r6_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(stat_q & ~clr_v)) == $past(stat_q & ~clr_v)));

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
   import uirq_pkg::*;
#(
   parameter int unsigned IRQ_W   = 13,
   parameter int unsigned NUM_EVT = 9,
   parameter int unsigned NUM_LIV = 4,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         bus_addr,
   input  logic               bus_wr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [NUM_LIV-1:0] live_i,
   output logic               irq_o
);

   localparam int unsigned PAD_W = REG_W - IRQ_W;

   generate
      if (IRQ_W >= REG_W || IRQ_W < 5) begin : g_bad_w
         $error("uart_irq_regs: IRQ_W out of range");
      end
      if (NUM_LIV != 4) begin : g_bad_liv
         $error("uart_irq_regs: channel view expects four live conditions");
      end
   endgenerate

   reg_sel_e           sel;
   logic [IRQ_W-1:0]   wd;
   logic [IRQ_W-1:0]   mask;
   logic [IRQ_W-1:0]   stat;
   logic [NUM_EVT-1:0] rise;
   logic [REG_W-1:0]   chan;
   logic               pend;
   logic               unused_hi;

   assign sel       = decode_addr(bus_addr);
   assign wd        = bus_wdata[IRQ_W-1:0];
   assign unused_hi = ^bus_wdata[REG_W-1:IRQ_W];

   uirq_edge #(.N(NUM_EVT)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (evt_i),
      .rise_o (rise)
   );

   uirq_mask #(.W(IRQ_W)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (bus_wr && sel == SEL_SETM),
      .clr_we (bus_wr && sel == SEL_CLRM),
      .wdata  (wd),
      .mask_o (mask)
   );

   uirq_status #(.W(IRQ_W), .N(NUM_EVT)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise_i (rise),
      .clr_we (bus_wr && sel == SEL_STAT),
      .wdata  (wd),
      .stat_o (stat)
   );

   always_comb begin
      chan    = '0;
      chan[0] = live_i[0];
      chan[1] = live_i[1];
      chan[3] = live_i[2];
      chan[4] = live_i[3];
   end

   always_comb begin
      case (sel)
         SEL_MASK: bus_rdata = {{PAD_W{1'b0}}, mask};
         SEL_STAT: bus_rdata = {{PAD_W{1'b0}}, stat};
         SEL_CHAN: bus_rdata = chan;
         default:  bus_rdata = '0;
      endcase
   end

   assign pend = |(stat & mask);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend;
         end
         assign irq_o = irq_q;

         a_r8_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o == ($past(stat & mask) != '0)));
      end else begin : g_irq_comb
         assign irq_o = pend;
      end
   endgenerate

   a_r4_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_SETM || sel == SEL_CLRM) |-> (bus_rdata == '0));

endmodule

// File: tb/uart_irq_regs_bench.sv
module uart_irq_regs_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [8:0]  evt_i = 9'h0;
   logic [3:0]  live_i = 4'h0;
   logic        irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   // behavioural reference state
   bit [31:0] m_mask, m_stat, m_prev;
   bit        m_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_irq_regs u_uart_irq_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_i     (evt_i),
      .live_i    (live_i),
      .irq_o     (irq_o)
   );

   always @(posedge clk or negedge rst_n) begin
      bit [31:0] rise, clr, wv;
      if (!rst_n) begin
         m_mask = 0; m_stat = 0; m_prev = 0; m_irq = 0;
      end else begin
         wv   = bus_wdata & 32'h1FFF;
         rise = {23'h0, evt_i} & ~m_prev;
         clr  = (bus_wr && bus_addr == 8'h14) ? wv : 0;
         m_irq = (m_stat & m_mask) != 0;
         m_stat = (m_stat & ~clr) | rise;
         if (bus_wr && bus_addr == 8'h08) m_mask = m_mask | wv;
         if (bus_wr && bus_addr == 8'h0C) m_mask = m_mask & ~wv;
         m_prev = {23'h0, evt_i};
      end
   end

   function automatic bit [31:0] exp_rd(input bit [7:0] a);
      case (a)
         8'h10: return m_mask;
         8'h14: return m_stat;
         8'h2C: return {27'h0, live_i[3], live_i[2], 1'b0, live_i[1], live_i[0]};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input bit [7:0] a);
      case (a)
         8'h10: return "R2";
         8'h14: return "R5";
         8'h2C: return "R9";
         8'h08, 8'h0C: return "R4";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic cmp();
      chk(irq_o === m_irq, "R8", {31'h0, irq_o}, {31'h0, m_irq});
      chk(bus_rdata === exp_rd(bus_addr), tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      cmp();
   endtask

   task automatic wr(input bit [7:0] a, input bit [31:0] d);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input bit [7:0] a, input bit [31:0] e, input string req);
      bus_addr = a; bus_wr = 1'b0;
      #1;
      chk(bus_rdata === e, req, bus_rdata, e);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         n_fail++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(irq_o === 1'b0, "R1", {31'h0, irq_o}, 32'h0);
      rd(8'h10, 32'h0, "R1");
      rd(8'h14, 32'h0, "R1");

      // R2 and R10: set all, only 13 bits exist
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h10, 32'h0000_1FFF, "R10");
      // R3 clear a subset
      wr(8'h0C, 32'h0000_0F0F);
      rd(8'h10, 32'h0000_10F0, "R3");
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h10, 32'h0, "R3");
      wr(8'h08, 32'h0000_0005);
      wr(8'h08, 32'h0000_0100);
      rd(8'h10, 32'h0000_0105, "R2");
      // R4 alias reads and read-only mask
      rd(8'h08, 32'h0, "R4");
      rd(8'h0C, 32'h0, "R4");
      wr(8'h10, 32'h0000_1FFF);
      rd(8'h10, 32'h0000_0105, "R4");
      // R11 unmapped address
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, 32'h0, "R11");
      rd(8'h10, 32'h0000_0105, "R11");

      // R5, R8: event on bit 0, irq one clock after status
      bus_addr = 8'h14;
      evt_i[0] = 1'b1;
      tick();
      rd(8'h14, 32'h1, "R5");
      chk(irq_o === 1'b0, "R8", {31'h0, irq_o}, 32'h0);
      tick();
      chk(irq_o === 1'b1, "R8", {31'h0, irq_o}, 32'h1);
      // R5: held line does not re-set after clear
      wr(8'h14, 32'h1);
      tick();
      rd(8'h14, 32'h0, "R5");
      chk(irq_o === 1'b0, "R8", {31'h0, irq_o}, 32'h0);
      evt_i[0] = 1'b0;
      tick();

      // R8: masked event raises status but not irq
      evt_i[6] = 1'b1; tick(); evt_i[6] = 1'b0;
      tick(); tick();
      rd(8'h14, 32'h40, "R5");
      chk(irq_o === 1'b0, "R8", {31'h0, irq_o}, 32'h0);

      // R6: zero bits are kept
      evt_i[2] = 1'b1; tick(); evt_i[2] = 1'b0; tick();
      rd(8'h14, 32'h44, "R6");
      wr(8'h14, 32'hFFFF_E004);
      rd(8'h14, 32'h40, "R6");

      // R7: rise and clear on the same bit in one cycle
      evt_i[2] = 1'b1;
      wr(8'h14, 32'h0000_0044);
      evt_i[2] = 1'b0;
      rd(8'h14, 32'h04, "R7");
      wr(8'h14, 32'h1FFF);
      rd(8'h14, 32'h0, "R6");

      // R9: live view ignores the mask
      wr(8'h0C, 32'h1FFF);
      live_i = 4'b1010; rd(8'h2C, 32'h12, "R9");
      live_i = 4'b0101; rd(8'h2C, 32'h09, "R9");
      live_i = 4'b1111; rd(8'h2C, 32'h1B, "R9");
      tick();

      // R10: all events, upper status bits stay zero
      evt_i = 9'h1FF; tick(); evt_i = 9'h0; tick();
      rd(8'h14, 32'h1FF, "R10");

      // randomized phase, compared on every clock
      for (int i = 0; i < 3000; i++) begin
         int unsigned r;
         r = $urandom;
         case (r % 7)
            0: bus_addr = 8'h08;
            1: bus_addr = 8'h0C;
            2: bus_addr = 8'h10;
            3, 4: bus_addr = 8'h14;
            5: bus_addr = 8'h2C;
            default: bus_addr = 8'h20;
         endcase
         bus_wr    = ((r >> 3) % 3) == 0;
         bus_wdata = $urandom;
         evt_i     = evt_i ^ (9'($urandom) & 9'($urandom) & 9'($urandom));
         live_i    = 4'($urandom);
         tick();
      end
      bus_wr = 1'b0;
      tick();

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule